// File: doc/BRIEF.md
# UART FIFO Control with DMA Ready Signaling

This block sits between a UART's host register file and its serializer. It holds one byte queue for each direction: the host pushes transmit bytes and the serializer pops them, while the deserializer pushes received bytes and the host pops them. A write-only control register turns the queues on and off. The same register also flushes either queue, picks the receive threshold and selects how the two active-low DMA request outputs behave. With the queues off, each direction shrinks to a single holding byte.

DMA signaling has two styles. The single-transfer style requests one byte at a time: transmit is requested when the transmit side is completely empty, and receive is requested when any received byte is waiting. The block style keeps transmit requested while any transmit slot is free, and keeps receive requested while the receive fill is at or above the programmed threshold. The receive queue keeps filling past the threshold until it is full. The receive request reaches its pin only when a pin-function select input picks that role.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After reset the queues are off, single-transfer style and threshold code 0 are selected, both directions are empty, tx_rdy_n is 0, rx_rdy_n is 1 and rx_overrun is 0.
- R2: A control write with bit 0 clear leaves the style (bit 3) and threshold (bits 7:6) unchanged and performs no flush, even when bit 1 or bit 2 is set.
- R3: Any control write that changes the queue enable (bit 0) empties both directions and clears rx_overrun.
- R4: A control write with bits 0 and 1 set empties the receive queue and clears rx_overrun, leaves the transmit queue alone, and has no lasting effect: later writes with bit 1 clear do not flush.
- R5: A control write with bits 0 and 2 set empties the transmit queue, leaves the receive queue alone, and does not repeat on later writes.
- R6: With the queues on, each direction holds DEPTH bytes in arrival order. A receive push into a full queue is dropped and sets rx_overrun, which stays set until a receive flush or an enable change.
- R7: With the queues off, each direction holds one byte. A second push is dropped, and for receive it sets rx_overrun.
- R8: A pop of a non-empty direction presents the oldest byte on its data output one cycle later. A pop of an empty direction leaves the data output at its last value and changes nothing else.
- R9: In single-transfer style, tx_rdy_n is 0 exactly when the transmit side is empty, and rx_rdy_n is 0 exactly when at least one received byte waits.
- R10: In block style (bit 3 = 1 with queues on), tx_rdy_n is 0 exactly while fewer than DEPTH transmit bytes are held.
- R11: In block style, rx_rdy_n is 0 exactly while the receive fill is at or above the threshold chosen by bits 7:6: 00 = 1, 01 = 4, 10 = 8, 11 = DEPTH-2 (14 by default).
- R12: rx_rdy_n stays 1 whenever rxrdy_sel is 0.
- R13: With the queues off, the request outputs follow single-transfer style whatever bit 3 last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| rxrdy_sel | input | 1 | Pin-function select: 1 routes the receive request to rx_rdy_n |
| host_tx_push | input | 1 | Host writes a transmit byte |
| host_tx_data | input | DATA_W | Transmit byte from host |
| ser_tx_pop | input | 1 | Serializer takes a transmit byte |
| ser_tx_data | output | DATA_W | Transmit byte for serializer, valid the cycle after a pop |
| ser_tx_avail | output | 1 | At least one transmit byte held |
| ser_rx_push | input | 1 | Deserializer delivers a received byte |
| ser_rx_data | input | DATA_W | Received byte from deserializer |
| host_rx_pop | input | 1 | Host reads a received byte |
| host_rx_data | output | DATA_W | Received byte for host, valid the cycle after a pop |
| host_rx_avail | output | 1 | At least one received byte held |
| rx_overrun | output | 1 | Sticky flag: a received byte was dropped |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |

## Verification
The overrun properties assume that no control write lands in the same cycle as a receive push into a full queue, because a flush in that cycle would clear the flag. The directed stimulus always issues control writes in cycles of their own, apart from any push or pop. The request-pin properties also take rxrdy_sel as a quasi-static input. The bench changes it only while the receive side is idle.

// File: rtl/uart_fdc_pkg.sv
package uart_fdc_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE   = 2'b00,
      TRIG_FOUR  = 2'b01,
      TRIG_EIGHT = 2'b10,
      TRIG_HIGH  = 2'b11
   } trig_sel_e;

   typedef struct packed {
      logic      q_on;
      logic      blk_style;
      trig_sel_e trig;
   } fdc_cfg_t;

   localparam int unsigned CTL_W       = 8;
   localparam int unsigned BIT_QON     = 0;
   localparam int unsigned BIT_RXFLUSH = 1;
   localparam int unsigned BIT_TXFLUSH = 2;
   localparam int unsigned BIT_STYLE   = 3;
   localparam int unsigned TRIG_LSB    = 6;

   function automatic int unsigned trig_entries(trig_sel_e t, int unsigned depth);
      case (t)
         TRIG_ONE:   return 1;
         TRIG_FOUR:  return 4;
         TRIG_EIGHT: return 8;
         default:    return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg
   import uart_fdc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output fdc_cfg_t         cfg,
   output logic             flush_rx,
   output logic             flush_tx
);

   fdc_cfg_t cfg_q;
   logic     en_bit;
   logic     en_change;

   assign en_bit    = wdata[BIT_QON];
   assign en_change = wr && (en_bit != cfg_q.q_on);

   // flush requests are single-cycle strobes; nothing of them is stored
   assign flush_rx = en_change || (wr && en_bit && wdata[BIT_RXFLUSH]);
   assign flush_tx = en_change || (wr && en_bit && wdata[BIT_TXFLUSH]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.q_on      <= 1'b0;
         cfg_q.blk_style <= 1'b0;
         cfg_q.trig      <= TRIG_ONE;
      end else if (wr) begin
         cfg_q.q_on <= en_bit;
         if (en_bit) begin
            cfg_q.blk_style <= wdata[BIT_STYLE];
            cfg_q.trig      <= trig_sel_e'(wdata[TRIG_LSB +: 2]);
         end
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/fdc_fifo.sv
module fdc_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              single,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  count,
   output logic              drop
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0]  cap;
   logic              full, do_push, do_pop;

   assign cap     = single ? CNT_W'(1) : CNT_W'(DEPTH);
   assign full    = (count >= cap);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && (count != '0) && !flush;
   assign drop    = push && full && !flush;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout <= '0;
      else if (do_pop) dout <= mem[rd_ptr];
   end

endmodule

// File: rtl/fdc_dma_ready.sv
module fdc_dma_ready
   import uart_fdc_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  fdc_cfg_t         cfg,
   input  logic             rxrdy_sel,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output logic             tx_rdy_n,
   output logic             rx_rdy_n
);

   logic             blk;
   logic [CNT_W-1:0] thresh;
   logic             tx_req, rx_req;

   assign blk    = cfg.q_on && cfg.blk_style;
   assign thresh = CNT_W'(trig_entries(cfg.trig, DEPTH));

   always_comb begin
      if (blk) begin
         tx_req = (tx_count < CNT_W'(DEPTH));
         rx_req = (rx_count >= thresh);
      end else begin
         tx_req = (tx_count == '0);
         rx_req = (rx_count != '0);
      end
   end

   assign tx_rdy_n = !tx_req;
   assign rx_rdy_n = !(rxrdy_sel && rx_req);

endmodule

// File: rtl/uart_fifo_dma_ctl.sv
module uart_fifo_dma_ctl
   import uart_fdc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   input  logic              rxrdy_sel,
   input  logic              host_tx_push,
   input  logic [DATA_W-1:0] host_tx_data,
   input  logic              ser_tx_pop,
   output logic [DATA_W-1:0] ser_tx_data,
   output logic              ser_tx_avail,
   input  logic              ser_rx_push,
   input  logic [DATA_W-1:0] ser_rx_data,
   input  logic              host_rx_pop,
   output logic [DATA_W-1:0] host_rx_data,
   output logic              host_rx_avail,
   output logic              rx_overrun,
   output logic              tx_rdy_n,
   output logic              rx_rdy_n
);

   generate
      if (DEPTH < 10)
         $fatal(1, "DEPTH must be at least 10 so every threshold fits");
      if (DATA_W < 1)
         $fatal(1, "DATA_W must be positive");
   endgenerate

   fdc_cfg_t         cfg;
   logic             flush_rx, flush_tx;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             rx_drop, tx_drop_unused;
   logic             q_on;
   logic             ovr_q;

   assign q_on = cfg.q_on;

   fdc_ctrl_reg u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .wdata    (cfg_wdata),
      .cfg      (cfg),
      .flush_rx (flush_rx),
      .flush_tx (flush_tx)
   );

   fdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush_tx),
      .single (!q_on),
      .push   (host_tx_push),
      .din    (host_tx_data),
      .pop    (ser_tx_pop),
      .dout   (ser_tx_data),
      .count  (tx_cnt),
      .drop   (tx_drop_unused)
   );

   fdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush_rx),
      .single (!q_on),
      .push   (ser_rx_push),
      .din    (ser_rx_data),
      .pop    (host_rx_pop),
      .dout   (host_rx_data),
      .count  (rx_cnt),
      .drop   (rx_drop)
   );

   fdc_dma_ready #(.DEPTH(DEPTH)) u_rdy (
      .cfg       (cfg),
      .rxrdy_sel (rxrdy_sel),
      .tx_count  (tx_cnt),
      .rx_count  (rx_cnt),
      .tx_rdy_n  (tx_rdy_n),
      .rx_rdy_n  (rx_rdy_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovr_q <= 1'b0;
      else if (flush_rx) ovr_q <= 1'b0;
      else if (rx_drop)  ovr_q <= 1'b1;
   end

   assign rx_overrun    = ovr_q;
   assign ser_tx_avail  = (tx_cnt != '0);
   assign host_rx_avail = (rx_cnt != '0);

endmodule

// File: rtl/uart_fdc_chk.sv
module uart_fdc_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [7:0]        cfg_wdata,
   input logic              rxrdy_sel,
   input logic              ser_rx_push,
   input logic              host_rx_pop,
   input logic [DATA_W-1:0] host_rx_data,
   input logic              rx_overrun,
   input logic              rx_rdy_n,
   input logic              q_on,
   input logic [CNT_W-1:0]  rx_cnt,
   input logic [CNT_W-1:0]  tx_cnt
);

   p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(DEPTH));

   p_single_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_on && !cfg_wr) |=> (rx_cnt <= 1 && tx_cnt <= 1));

   p_pin_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rxrdy_sel |-> rx_rdy_n);

   p_rx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_cnt == '0 && !rx_overrun));

   p_enable_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_wdata[0] != q_on)) |=> (rx_cnt == '0 && tx_cnt == '0));

   p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_rx_push && !cfg_wr && rx_cnt == (q_on ? CNT_W'(DEPTH) : CNT_W'(1))) |=> rx_overrun);

   p_overrun_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && !cfg_wr) |=> rx_overrun);

   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rx_pop && rx_cnt == '0) |=> $stable(host_rx_data));

endmodule

bind uart_fifo_dma_ctl uart_fdc_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .cfg_wdata    (cfg_wdata),
   .rxrdy_sel    (rxrdy_sel),
   .ser_rx_push  (ser_rx_push),
   .host_rx_pop  (host_rx_pop),
   .host_rx_data (host_rx_data),
   .rx_overrun   (rx_overrun),
   .rx_rdy_n     (rx_rdy_n),
   .q_on         (q_on),
   .rx_cnt       (rx_cnt),
   .tx_cnt       (tx_cnt)
);

// File: tb/sim_uart_fifo_dma_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_dma_ctl;

   localparam int DW = 8;
   localparam int DP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic          rxrdy_sel = 1'b1;
   logic          host_tx_push = 1'b0;
   logic [DW-1:0] host_tx_data = '0;
   logic          ser_tx_pop = 1'b0;
   logic [DW-1:0] ser_tx_data;
   logic          ser_tx_avail;
   logic          ser_rx_push = 1'b0;
   logic [DW-1:0] ser_rx_data = '0;
   logic          host_rx_pop = 1'b0;
   logic [DW-1:0] host_rx_data;
   logic          host_rx_avail;
   logic          rx_overrun;
   logic          tx_rdy_n;
   logic          rx_rdy_n;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   uart_fifo_dma_ctl #(.DATA_W(DW), .DEPTH(DP)) u0 (.*);

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(logic [7:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic rx_in(logic [DW-1:0] d);
      @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = d;
      @(negedge clk); ser_rx_push = 1'b0;
   endtask

   task automatic tx_in(logic [DW-1:0] d);
      @(negedge clk); host_tx_push = 1'b1; host_tx_data = d;
      @(negedge clk); host_tx_push = 1'b0;
   endtask

   task automatic rx_out();
      @(negedge clk); host_rx_pop = 1'b1;
      @(negedge clk); host_rx_pop = 1'b0;
   endtask

   task automatic tx_out();
      @(negedge clk); ser_tx_pop = 1'b1;
      @(negedge clk); ser_tx_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 tx_rdy_n", tx_rdy_n, 0);
      chk("R1 rx_rdy_n", rx_rdy_n, 1);
      chk("R1 overrun", rx_overrun, 0);
      chk("R1 rx_avail", host_rx_avail, 0);
      chk("R1 tx_avail", ser_tx_avail, 0);
   endtask

   task automatic t_single();
      rx_in(8'hA5);
      chk("R9 rx req on byte", rx_rdy_n, 0);
      rx_in(8'h3C);
      chk("R7 second rx dropped -> overrun", rx_overrun, 1);
      rx_out();
      chk("R8 rx data", host_rx_data, 8'hA5);
      chk("R7 only one byte held", host_rx_avail, 0);
      chk("R9 rx req off", rx_rdy_n, 1);
      rx_out();
      chk("R8 empty pop keeps data", host_rx_data, 8'hA5);
      tx_in(8'h11);
      chk("R9 tx req off when held", tx_rdy_n, 1);
      tx_in(8'h22);
      tx_out();
      chk("R7 tx first byte", ser_tx_data, 8'h11);
      chk("R7 tx second dropped", ser_tx_avail, 0);
      chk("R9 tx req back", tx_rdy_n, 0);
   endtask

   task automatic t_ignore();
      rx_in(8'h5A);
      tx_in(8'h6B);
      wr_ctl(8'h02);
      chk("R2 rx flush ignored", host_rx_avail, 1);
      chk("R2 overrun kept", rx_overrun, 1);
      wr_ctl(8'h04);
      chk("R2 tx flush ignored", ser_tx_avail, 1);
   endtask

   task automatic t_enable();
      wr_ctl(8'h01);
      chk("R3 rx emptied", host_rx_avail, 0);
      chk("R3 tx emptied", ser_tx_avail, 0);
      chk("R3 overrun cleared", rx_overrun, 0);
   endtask

   task automatic t_depth();
      for (int i = 0; i < DP; i++) rx_in(DW'(i * 3 + 1));
      chk("R6 full no overrun", rx_overrun, 0);
      chk("R9 rx req in fifo mode0", rx_rdy_n, 0);
      rx_in(8'hEE);
      chk("R6 overrun on full", rx_overrun, 1);
      for (int i = 0; i < DP; i++) begin
         rx_out();
         chk("R6 order", host_rx_data, (i * 3 + 1) & 8'hFF);
      end
      chk("R6 empty after drain", host_rx_avail, 0);
      rx_out();
      chk("R8 empty pop", host_rx_data, ((DP - 1) * 3 + 1) & 8'hFF);
      chk("R6 overrun sticky", rx_overrun, 1);
   endtask

   task automatic t_flush();
      rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
      tx_in(8'h81); tx_in(8'h82);
      wr_ctl(8'h03);
      chk("R4 rx emptied", host_rx_avail, 0);
      chk("R4 overrun cleared", rx_overrun, 0);
      chk("R4 tx kept", ser_tx_avail, 1);
      rx_in(8'h44);
      wr_ctl(8'h01);
      chk("R4 flush self-clears", host_rx_avail, 1);
      wr_ctl(8'h05);
      chk("R5 tx emptied", ser_tx_avail, 0);
      chk("R5 rx kept", host_rx_avail, 1);
      tx_in(8'h90);
      wr_ctl(8'h01);
      chk("R5 flush self-clears", ser_tx_avail, 1);
      wr_ctl(8'h07);
   endtask

   task automatic t_block();
      int lv;
      for (int c = 0; c < 4; c++) begin
         lv = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : DP - 2;
         wr_ctl(8'h0F | 8'(c << 6));
         for (int i = 0; i < lv - 1; i++) rx_in(DW'(i));
         chk("R11 below threshold", rx_rdy_n, 1);
         rx_in(8'h55);
         chk("R11 at threshold", rx_rdy_n, 0);
         rx_in(8'h56);
         chk("R11 above threshold", rx_rdy_n, 0);
      end
      wr_ctl(8'h07);
      for (int i = 0; i < DP - 1; i++) tx_in(DW'(i));
      chk("R9 mode0 tx not empty", tx_rdy_n, 1);
      wr_ctl(8'h09);
      chk("R10 slot free", tx_rdy_n, 0);
      tx_in(8'hFF);
      chk("R10 full", tx_rdy_n, 1);
      tx_out();
      chk("R10 slot freed", tx_rdy_n, 0);
      wr_ctl(8'hCF);
      wr_ctl(8'h08);
      rx_in(8'h12);
      chk("R13 off -> single style rx", rx_rdy_n, 0);
      chk("R13 off -> single style tx", tx_rdy_n, 0);
   endtask

   task automatic t_pinsel();
      @(negedge clk); rxrdy_sel = 1'b0;
      @(negedge clk);
      chk("R12 pin not selected", rx_rdy_n, 1);
      rxrdy_sel = 1'b1;
      @(negedge clk);
      chk("R12 pin selected again", rx_rdy_n, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_ignore();
      t_enable();
      t_depth();
      t_flush();
      t_block();
      t_pinsel();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule